// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies even parity for a 32-bit multiplexed address/data bus together with its 4 command/byte-enable lines. In every clock it samples the bus lines and folds all 36 bits into a single parity bit. The bit is registered, so the parity line always lags the lines it covers by exactly one clock. The parity output enable is the address/data drive enable delayed by one clock. As a result, whenever the local agent drove the bus in one clock, it drives the matching parity in the next.

When the local agent is the receiving party, the block checks the parity line against the bit it computed itself. It decides from the FRAME, IRDY and TRDY handshake whether the previous clock was an address phase or a completed data phase. A mismatch after a data phase gives a one-clock low pulse on the data parity error output two clocks after the faulty data. A mismatch after an address phase gives the same kind of pulse on the separate system error output. Each pulse is gated by its own enable. For each error type a sticky status bit records the detection, and a write-one-to-clear input clears it.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_o` equals the XOR of all bits of `ad_i` and `cbe_i`, as sampled in the previous clock, so that together with those 36 bits the count of ones is even.
- R2: `par_oe_o` equals `ad_oe_i` of the previous clock, so parity is driven exactly one clock after each clock in which the local agent drove the bus.
- R3: A clock is an address phase when `frame_n_i` is 0 and the previous clock had both `frame_n_i` and `irdy_n_i` at 1. If `ad_oe_i` is 0 in that clock and `par_i` in the next clock differs from the computed parity, `serr_n_o` is 0 for exactly one clock, two clocks after the address phase.
- R4: A clock that is not an address phase and has both `irdy_n_i` and `trdy_n_i` at 0 is a completed data phase. If `ad_oe_i` is 0 in that clock and `par_i` in the next clock is wrong, `perr_n_o` is 0 for exactly one clock, two clocks after the data phase.
- R5: Address parity errors never pulse `perr_n_o`, and data parity errors never pulse `serr_n_o`.
- R6: A phase in which `ad_oe_i` is 1 is never checked. Wrong `par_i` after such a phase causes no pulse and sets no status bit.
- R7: A clock with `irdy_n_i` or `trdy_n_i` at 1 that is not an address phase is not checked.
- R8: A pulse appears only if its enable was 1 in the clock in which parity was checked. That is `perr_en_i` for `perr_n_o` and `serr_en_i` for `serr_n_o`.
- R9: `perr_sts_o` and `serr_sts_o` go to 1 in the same clock as the pulse would appear, whatever the enables are. Each holds until a 1 on `sts_clr_i[0]` (data) or `sts_clr_i[1]` (address) clears it one clock later. A new detection wins over a simultaneous clear.
- R10: While `rst_n` is 0 at a clock edge, `par_o` and `par_oe_o` become 0, `perr_n_o` and `serr_n_o` become 1, and both status bits become 0. The bus is then treated as idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 32 | Sampled address/data lines |
| cbe_i | input | 4 | Sampled command/byte-enable lines |
| par_i | input | 1 | Sampled parity line |
| ad_oe_i | input | 1 | Local agent drives address/data in this clock |
| frame_n_i | input | 1 | FRAME handshake, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| perr_en_i | input | 1 | Enables data parity error reporting |
| serr_en_i | input | 1 | Enables address parity error reporting |
| sts_clr_i | input | 2 | Write-one-to-clear: bit 0 data status, bit 1 address status |
| par_o | output | 1 | Generated parity, one clock behind the bus |
| par_oe_o | output | 1 | Parity drive enable |
| perr_n_o | output | 1 | Data parity error pulse, active low |
| serr_n_o | output | 1 | Address parity error pulse, active low |
| perr_sts_o | output | 1 | Sticky data parity error flag |
| serr_sts_o | output | 1 | Sticky address parity error flag |

## Verification
The generated parity and its enable are due one clock after the lines are presented. The parity line for a phase is applied one clock after that phase. The error pulse and the status bit follow two clocks after the phase. Each scenario task drives one input step per clock, with changes one nanosecond after the rising edge. It reads the outputs in the step where they are due and again in the step after, to confirm that each pulse lasts exactly one clock. The cases where nothing should happen (own drive, incomplete handshake, disabled report) are read in the same steps, on the pulse outputs and the status bits.

// File: rtl/bus_parity_pkg.sv
// Package: shared widths and error-type indices for the bus parity unit.
// Assumes: one data error and one address error type, indexed as below.
package bus_parity_pkg;
    localparam int AD_W   = 32;
    localparam int CBE_W  = 4;
    localparam int ERR_N  = 2;
    localparam int ERR_DATA = 0;
    localparam int ERR_ADDR = 1;
endpackage

// File: rtl/par_tree.sv
// Module: par_tree
// Folds a vector into one even-parity bit with a balanced XOR tree.
// Assumes: W >= 1; purely combinational.
module par_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] vec_i,
    output logic         par_o
);
    localparam int LEVELS = (W <= 1) ? 1 : $clog2(W);
    localparam int PAD_W  = 1 << LEVELS;

    logic [PAD_W-1:0] lvl [LEVELS+1];

    // Zero-extend the input into the first tree level.
    always_comb begin
        lvl[0] = '0;
        lvl[0][W-1:0] = vec_i;
    end

    genvar l, n;
    generate
        for (l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int NODES = PAD_W >> (l + 1);
            for (n = 0; n < NODES; n++) begin : g_node
                assign lvl[l+1][n] = lvl[l][2*n] ^ lvl[l][2*n+1];
            end
            if (NODES < PAD_W) begin : g_fill
                assign lvl[l+1][PAD_W-1:NODES] = '0;
            end
        end
    endgenerate

    assign par_o = lvl[LEVELS][0];
endmodule

// File: rtl/par_gen.sv
// Module: par_gen
// Registers the parity of the bus lines and the delayed parity drive enable.
// Assumes: lines are valid at each clock edge; the registered parity is also
// the expected value used by the checker.
module par_gen #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             ad_oe_i,
    output logic             par_q_o,
    output logic             par_oe_q_o
);
    localparam int TOT_W = AD_W + CBE_W;

    logic par_now;

    par_tree #(.W(TOT_W)) u_tree (
        .vec_i ({ad_i, cbe_i}),
        .par_o (par_now)
    );

    // Pipeline parity and its enable one clock behind the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q_o    <= 1'b0;
            par_oe_q_o <= 1'b0;
        end else begin
            par_q_o    <= par_now;
            par_oe_q_o <= ad_oe_i;
        end
    end
endmodule

// File: rtl/phase_det.sv
// Module: phase_det
// Classifies each clock as address phase, completed data phase or neither.
// It flags the phases the local agent received, so they are checked in the next clock.
// Assumes: handshake inputs are active low; an address phase takes priority.
module phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_i,
    input  logic irdy_n_i,
    input  logic trdy_n_i,
    input  logic ad_oe_i,
    output logic chk_addr_q_o,
    output logic chk_data_q_o
);
    logic prev_idle_q;
    logic addr_now;
    logic data_now;

    // Decode the current phase from the handshake and the previous idle state.
    always_comb begin
        addr_now = !frame_n_i && prev_idle_q;
        data_now = !irdy_n_i && !trdy_n_i && !addr_now;
    end

    // Track bus idle and register which received phases need a check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_idle_q  <= 1'b1;
            chk_addr_q_o <= 1'b0;
            chk_data_q_o <= 1'b0;
        end else begin
            prev_idle_q  <= frame_n_i && irdy_n_i;
            chk_addr_q_o <= addr_now && !ad_oe_i;
            chk_data_q_o <= data_now && !ad_oe_i;
        end
    end
endmodule

// File: rtl/err_report.sv
// Module: err_report
// Compares the parity line with the expected bit and registers the gated error
// pulses and the sticky status bits, one pair per error type.
// Assumes: the check flags and the expected parity refer to the previous clock.
module err_report
    import bus_parity_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_i,
    input  logic             exp_par_i,
    input  logic             chk_addr_i,
    input  logic             chk_data_i,
    input  logic             perr_en_i,
    input  logic             serr_en_i,
    input  logic [ERR_N-1:0] sts_clr_i,
    output logic             perr_n_o,
    output logic             serr_n_o,
    output logic [ERR_N-1:0] sts_o
);
    logic             mism;
    logic [ERR_N-1:0] hit;
    logic [ERR_N-1:0] en;
    logic [ERR_N-1:0] pulse_q;
    logic [ERR_N-1:0] sts_q;

    // Detect a mismatch and route it to the error type of the checked phase.
    always_comb begin
        mism           = par_i ^ exp_par_i;
        hit[ERR_DATA]  = chk_data_i && mism;
        hit[ERR_ADDR]  = chk_addr_i && mism;
        en[ERR_DATA]   = perr_en_i;
        en[ERR_ADDR]   = serr_en_i;
    end

    genvar i;
    generate
        for (i = 0; i < ERR_N; i++) begin : g_err
            // Register the gated pulse and the sticky flag; set beats clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pulse_q[i] <= 1'b0;
                    sts_q[i]   <= 1'b0;
                end else begin
                    pulse_q[i] <= hit[i] && en[i];
                    sts_q[i]   <= hit[i] || (sts_q[i] && !sts_clr_i[i]);
                end
            end
        end
    endgenerate

    assign perr_n_o = !pulse_q[ERR_DATA];
    assign serr_n_o = !pulse_q[ERR_ADDR];
    assign sts_o    = sts_q;
endmodule

// File: rtl/bus_parity_unit.sv
// Module: bus_parity_unit (top)
// Even-parity generator and checker for a multiplexed address/data bus with
// command/byte-enable lines. Parity lags the bus by one clock; errors are
// reported two clocks after the faulty phase on separate data/address outputs.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module bus_parity_unit
    import bus_parity_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             par_i,
    input  logic             ad_oe_i,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic             trdy_n_i,
    input  logic             perr_en_i,
    input  logic             serr_en_i,
    input  logic [ERR_N-1:0] sts_clr_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_n_o,
    output logic             serr_n_o,
    output logic             perr_sts_o,
    output logic             serr_sts_o
);
    logic             par_q;
    logic             chk_addr_q;
    logic             chk_data_q;
    logic [ERR_N-1:0] sts;

    par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_i       (ad_i),
        .cbe_i      (cbe_i),
        .ad_oe_i    (ad_oe_i),
        .par_q_o    (par_q),
        .par_oe_q_o (par_oe_o)
    );

    phase_det u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n_i),
        .irdy_n_i     (irdy_n_i),
        .trdy_n_i     (trdy_n_i),
        .ad_oe_i      (ad_oe_i),
        .chk_addr_q_o (chk_addr_q),
        .chk_data_q_o (chk_data_q)
    );

    err_report u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_i      (par_i),
        .exp_par_i  (par_q),
        .chk_addr_i (chk_addr_q),
        .chk_data_i (chk_data_q),
        .perr_en_i  (perr_en_i),
        .serr_en_i  (serr_en_i),
        .sts_clr_i  (sts_clr_i),
        .perr_n_o   (perr_n_o),
        .serr_n_o   (serr_n_o),
        .sts_o      (sts)
    );

    assign par_o      = par_q;
    assign perr_sts_o = sts[ERR_DATA];
    assign serr_sts_o = sts[ERR_ADDR];
endmodule

// File: rtl/bus_parity_unit_chk.sv
// Module: bus_parity_unit_chk
// Assertion checker bound to bus_parity_unit; observes ports only.
// Assumes: a small cycle counter guards every look into the past after reset.
module bus_parity_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ad_i,
    input logic [3:0]  cbe_i,
    input logic        ad_oe_i,
    input logic        irdy_n_i,
    input logic        trdy_n_i,
    input logic        perr_en_i,
    input logic        serr_en_i,
    input logic [1:0]  sts_clr_i,
    input logic        par_o,
    input logic        par_oe_o,
    input logic        perr_n_o,
    input logic        serr_n_o,
    input logic        perr_sts_o,
    input logic        serr_sts_o
);
    logic [1:0] cyc_q;

    // Count clocks since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)            cyc_q <= 2'd0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    AST_PAR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1) |-> (par_o == $past(^{ad_i, cbe_i}))); // R1

    AST_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1) |-> (par_oe_o == $past(ad_oe_i))); // R2

    AST_PERR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && !perr_n_o) |->
            ($past(!irdy_n_i && !trdy_n_i && !ad_oe_i, 2))); // R4

    AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1 && !perr_n_o) |-> $past(perr_en_i)); // R8

    AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd1 && !serr_n_o) |-> $past(serr_en_i)); // R8

    AST_PERR_STS: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> perr_sts_o); // R9

    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_sts_o && !sts_clr_i[0]) |=> perr_sts_o); // R9

    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_sts_o && !sts_clr_i[1]) |=> serr_sts_o); // R9
endmodule

bind bus_parity_unit bus_parity_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_i),
    .cbe_i      (cbe_i),
    .ad_oe_i    (ad_oe_i),
    .irdy_n_i   (irdy_n_i),
    .trdy_n_i   (trdy_n_i),
    .perr_en_i  (perr_en_i),
    .serr_en_i  (serr_en_i),
    .sts_clr_i  (sts_clr_i),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o),
    .perr_n_o   (perr_n_o),
    .serr_n_o   (serr_n_o),
    .perr_sts_o (perr_sts_o),
    .serr_sts_o (serr_sts_o)
);

// File: tb/bus_parity_unit_tb.sv
// Directed bench for bus_parity_unit: one task per scenario, each checking itself.
module bus_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad_i;
    logic [3:0]  cbe_i;
    logic        par_i;
    logic        ad_oe_i;
    logic        frame_n_i;
    logic        irdy_n_i;
    logic        trdy_n_i;
    logic        perr_en_i;
    logic        serr_en_i;
    logic [1:0]  sts_clr_i;
    logic        par_o, par_oe_o, perr_n_o, serr_n_o, perr_sts_o, serr_sts_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
        .ad_oe_i(ad_oe_i), .frame_n_i(frame_n_i), .irdy_n_i(irdy_n_i),
        .trdy_n_i(trdy_n_i), .perr_en_i(perr_en_i), .serr_en_i(serr_en_i),
        .sts_clr_i(sts_clr_i), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_n_o(perr_n_o), .serr_n_o(serr_n_o), .perr_sts_o(perr_sts_o),
        .serr_sts_o(serr_sts_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        frame_n_i = 1'b1; irdy_n_i = 1'b1; trdy_n_i = 1'b1;
        ad_oe_i = 1'b0; par_i = 1'b0; sts_clr_i = 2'b00;
    endtask

    // One transaction: address phase, one data phase, then idle.
    // bad_a/bad_d corrupt the parity applied for each phase; done=0 leaves TRDY high.
    // Observes pulse outputs two (s2,p2) and three (s3,p3) clocks after the address phase.
    task automatic txn(input logic [31:0] a, input logic [3:0] ca,
                       input logic [31:0] d, input logic [3:0] cd,
                       input logic bad_a, input logic bad_d, input logic oe,
                       input logic done,
                       output logic s2, output logic p2, output logic s3,
                       output logic p3, output logic sts2, output logic sts3);
        ad_i = a; cbe_i = ca; frame_n_i = 1'b0; ad_oe_i = oe;
        tick();
        ad_i = d; cbe_i = cd; irdy_n_i = 1'b0; trdy_n_i = !done;
        par_i = (^{a, ca}) ^ bad_a;
        tick();
        s2 = serr_n_o; p2 = perr_n_o; sts2 = serr_sts_o;
        idle();
        par_i = (^{d, cd}) ^ bad_d;
        tick();
        s3 = serr_n_o; p3 = perr_n_o; sts3 = perr_sts_o;
        par_i = 1'b0;
        tick();
    endtask

    task automatic clear_all();
        sts_clr_i = 2'b11;
        tick();
        sts_clr_i = 2'b00;
    endtask

    task automatic t_reset();
        idle(); ad_i = 32'hFFFF_FFFF; cbe_i = 4'h1; perr_en_i = 1'b1; serr_en_i = 1'b1;
        ad_oe_i = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        check("R10 par_o", par_o, 1'b0);
        check("R10 par_oe_o", par_oe_o, 1'b0);
        check("R10 perr_n_o", perr_n_o, 1'b1);
        check("R10 serr_n_o", serr_n_o, 1'b1);
        check("R10 status", {perr_sts_o, serr_sts_o}, 2'b00);
        ad_oe_i = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_generate();
        logic [31:0] pats [4] = '{32'h0000_0000, 32'h0000_0001, 32'hA5A5_5A5A, 32'h8000_0003};
        logic [3:0]  cb   [4] = '{4'h0, 4'h0, 4'h1, 4'hF};
        for (int k = 0; k < 4; k++) begin
            ad_i = pats[k]; cbe_i = cb[k]; ad_oe_i = (k % 2 == 0);
            tick();
            check("R1 parity", par_o, ^{pats[k], cb[k]});
            check("R2 parity enable", par_oe_o, (k % 2 == 0));
        end
        idle();
        tick();
        check("R2 enable drops", par_oe_o, 1'b0);
    endtask

    task automatic t_data_err();
        logic s2, p2, s3, p3, st2, st3;
        txn(32'h1234_5678, 4'h6, 32'hDEAD_BEEF, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1,
            s2, p2, s3, p3, st2, st3);
        check("R4 no early perr", p2, 1'b1);
        check("R4 perr two clocks after data", p3, 1'b0);
        check("R5 data error not on serr", s3, 1'b1);
        check("R9 perr status set", st3, 1'b1);
        check("R4 perr one clock only", perr_n_o, 1'b1);
        check("R9 perr status held", perr_sts_o, 1'b1);
        check("R5 serr status untouched", serr_sts_o, 1'b0);
        clear_all();
        tick();
        check("R9 perr status cleared", perr_sts_o, 1'b0);
    endtask

    task automatic t_addr_err();
        logic s2, p2, s3, p3, st2, st3;
        txn(32'h0F0F_0001, 4'h7, 32'h0000_0010, 4'h0, 1'b1, 1'b0, 1'b0, 1'b1,
            s2, p2, s3, p3, st2, st3);
        check("R3 serr two clocks after address", s2, 1'b0);
        check("R5 address error not on perr", p2, 1'b1);
        check("R9 serr status set", st2, 1'b1);
        check("R3 serr one clock only", s3, 1'b1);
        check("R5 good data no perr", p3, 1'b1);
        check("R5 perr status untouched", st3, 1'b0);
        clear_all();
        tick();
        check("R9 serr status cleared", serr_sts_o, 1'b0);
    endtask

    task automatic t_own_drive();
        logic s2, p2, s3, p3, st2, st3;
        txn(32'h5555_AAAA, 4'h3, 32'hCAFE_0001, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1,
            s2, p2, s3, p3, st2, st3);
        check("R6 own address unchecked", s2, 1'b1);
        check("R6 own data unchecked", p3, 1'b1);
        check("R6 no status", {perr_sts_o, serr_sts_o}, 2'b00);
    endtask

    task automatic t_incomplete();
        logic s2, p2, s3, p3, st2, st3;
        txn(32'h0000_1000, 4'h6, 32'h7777_7777, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0,
            s2, p2, s3, p3, st2, st3);
        check("R7 incomplete phase unchecked", p3, 1'b1);
        check("R7 no perr status", st3, 1'b0);
    endtask

    task automatic t_disabled();
        logic s2, p2, s3, p3, st2, st3;
        perr_en_i = 1'b0; serr_en_i = 1'b0;
        txn(32'h1111_0000, 4'h7, 32'h2222_0000, 4'hC, 1'b1, 1'b1, 1'b0, 1'b1,
            s2, p2, s3, p3, st2, st3);
        check("R8 serr gated", s2, 1'b1);
        check("R8 perr gated", p3, 1'b1);
        check("R9 serr status despite gate", st2, 1'b1);
        check("R9 perr status despite gate", st3, 1'b1);
        perr_en_i = 1'b1; serr_en_i = 1'b1;
        clear_all();
        tick();
    endtask

    task automatic t_set_wins();
        logic [31:0] d = 32'h0000_00F1;
        ad_i = 32'h4; cbe_i = 4'h7; frame_n_i = 1'b0;
        tick();
        ad_i = d; cbe_i = 4'h0; irdy_n_i = 1'b0; trdy_n_i = 1'b0;
        par_i = ^{32'h4, 4'h7};
        tick();
        idle();
        par_i = ~(^{d, 4'h0});
        sts_clr_i = 2'b01;
        tick();
        sts_clr_i = 2'b00; par_i = 1'b0;
        check("R9 set wins over clear", perr_sts_o, 1'b1);
        clear_all();
        tick();
        check("R9 cleared afterwards", perr_sts_o, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ad_i = '0; cbe_i = '0; perr_en_i = 1'b1; serr_en_i = 1'b1;
        idle();
        t_reset();
        t_generate();
        t_data_err();
        t_addr_err();
        t_own_drive();
        t_incomplete();
        t_disabled();
        t_set_wins();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule